// File: doc/BRIEF.md
# Interval Timer with Reload

This block is a countdown timer that sits on a processor's local peripheral bus as a single 32-bit register. A bus write both loads a start count and picks the behaviour at expiry. In one-shot mode the counter runs down to zero and parks there. In auto-reload mode it refills itself from the stored start value and keeps running with no further software action.

Counting advances only while an external run-enable is high. That input is normally tied to "processor not halted", so the timer freezes while a debugger holds the core. When the count expires, the block raises a one-clock timeout pulse. The logic is the same whether that pulse feeds an interrupt controller or, for watchdog duty, a reset line.

Top module: `ivl_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, reload value and mode clear to zero and `tmo` and `wb_ack` are low; a read after reset returns 0.
- R2: A write (`wb_cyc`, `wb_stb` and `wb_we` all high) loads the count and the reload value from bits 30:0 and the mode from bit 31 (1 = auto-reload, 0 = one-shot); a read returns the mode in bit 31 and the count in bits 30:0, sampled at the strobe edge.
- R3: `wb_ack` is high exactly one clock after each edge that sees `wb_cyc` and `wb_stb` high (read or write), low otherwise, and `wb_stall` is always low.
- R4: At each edge where `run_en` is high, no write occurs and the count is above 1, the count drops by exactly one.
- R5: At an edge where `run_en` is low and no write occurs, the count and mode keep their values.
- R6: In one-shot mode, the edge that takes the count from 1 to 0 makes `tmo` high for one clock; the count then stays 0 and `tmo` is not raised again.
- R7: In auto-reload mode, the edge that would take the count from 1 to 0 instead loads the reload value and makes `tmo` high for one clock, so a start value N gives one pulse every N enabled clocks.
- R8: Writing a count of zero (either mode) leaves the count at zero with no `tmo` pulse for as long as it is enabled.
- R9: A write at the same edge as an enabled decrement wins: the count equals the written value, not one less.
- R10: A strobe with `wb_cyc` low is ignored: no ack, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Count enable (processor running) |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_dat_i | input | 32 | Write data: mode bit 31, start count 30:0 |
| wb_ack | output | 1 | Access acknowledge, one clock after strobe |
| wb_stall | output | 1 | Always low |
| wb_dat_o | output | 32 | Read data: mode bit 31, count 30:0 |
| tmo | output | 1 | One-clock expiry pulse (interrupt or reset source) |

## Verification
The hardest state to reach from the ports is the edge where a count of exactly 1 meets an active enable. That edge must be told apart from a stop one cycle early or one cycle late, and for auto-reload from a reload that passes through zero. The stimulus freezes the timer with `run_en` low, loads known values, and then opens the enable for an exact number of edges. It reads the count back only while frozen, so every expected count and pulse total follows from arithmetic on the window length. A reload value of 1 drives the reload branch on every enabled edge.

// File: rtl/ivl_timer_pkg.sv
// Package: shared widths and the register word layout for the interval timer.
// Assumes a word of at least two bits; the top bit is always the mode bit.
package ivl_timer_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RELOAD  = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/ivl_timer_core.sv
// Module: ivl_timer_core
// Holds the count, the reload value and the mode. It loads all three on a
// bus write, decrements while enabled, and emits a one-clock expiry pulse.
// Assumes wr_en is already qualified by cyc/stb/we; reset is synchronous, active low.
module ivl_timer_core
    import ivl_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic             wr_mode,
    input  logic [CNT_W-1:0] wr_count,
    output logic [CNT_W-1:0] count,
    output tmr_mode_e        mode,
    output logic             tmo
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] reload_q;
    logic             at_one;
    logic             step;

    // Purpose: decode when an enabled edge will expire the count.
    always_comb begin
        at_one = (count == ONE);
        step   = run_en && !wr_en && (count != ZERO);
    end

    // Purpose: count register, reload register and mode, with writes taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= ZERO;
            reload_q <= ZERO;
            mode     <= MODE_ONESHOT;
        end else if (wr_en) begin
            count    <= wr_count;
            reload_q <= wr_count;
            mode     <= tmr_mode_e'(wr_mode);
        end else if (step) begin
            if (at_one && mode == MODE_RELOAD)
                count <= reload_q;
            else
                count <= count - ONE;
        end
    end

    // Purpose: one-clock expiry pulse on the edge that consumes the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo <= 1'b0;
        else
            tmo <= step && at_one;
    end

    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !wr_en && count > ONE) |=> (count == $past(count) - ONE));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> ($stable(count) && $stable(mode)));
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !wr_en && count == ONE && mode == MODE_RELOAD)
        |=> (count == reload_q && tmo));
    a_r6_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count == ZERO && !wr_en) |=> (count == ZERO && !tmo));
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_count)));
endmodule

// File: rtl/ivl_timer_bus.sv
// Module: ivl_timer_bus
// Single-register pipelined bus slave: it decodes writes, acknowledges every
// strobe one clock later, never stalls, and captures read data at the strobe edge.
// Assumes one register only, so no address decode is needed.
module ivl_timer_bus #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [WORD_W-1:0] status,
    output logic              wr_en,
    output logic              ack,
    output logic              stall,
    output logic [WORD_W-1:0] rdata
);
    logic sel;

    // Purpose: qualify the strobe and derive the write enable.
    always_comb begin
        sel   = cyc && stb;
        wr_en = sel && we;
        stall = 1'b0;
    end

    // Purpose: ack one clock after each strobe, read data captured alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= sel;
            if (sel)
                rdata <= status;
        end
    end

    a_r3_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && stb) |=> ack);
    a_r10_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc && stb) |=> !ack);
endmodule

// File: rtl/ivl_timer.sv
// Module: ivl_timer (top)
// Memory-mapped countdown timer with a one-shot or auto-reload mode. Bit 31 of
// the register word is the mode, and the low bits are the count.
// Assumes run_en is synchronous to clk; tmo may drive an interrupt or a reset.
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic              wb_ack,
    output logic              wb_stall,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              tmo
);
    localparam int unsigned CNT_W = DATA_W - 1;

    logic             wr_en;
    logic [CNT_W-1:0] count;
    tmr_mode_e        mode;
    logic [DATA_W-1:0] status;

    // Purpose: pack the mode and count into the readable word.
    always_comb status = {mode, count};

    ivl_timer_bus #(.WORD_W(DATA_W)) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc    (wb_cyc),
        .stb    (wb_stb),
        .we     (wb_we),
        .status (status),
        .wr_en  (wr_en),
        .ack    (wb_ack),
        .stall  (wb_stall),
        .rdata  (wb_dat_o)
    );

    ivl_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .wr_en    (wr_en),
        .wr_mode  (wb_dat_i[DATA_W-1]),
        .wr_count (wb_dat_i[CNT_W-1:0]),
        .count    (count),
        .mode     (mode),
        .tmo      (tmo)
    );

    a_r8_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wb_dat_i[CNT_W-1:0] == '0) |=> !tmo);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!tmo && !wb_ack && count == '0));
endmodule

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wb_cyc = 1'b0;
    logic        wb_stb = 1'b0;
    logic        wb_we = 1'b0;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack;
    logic        wb_stall;
    logic [31:0] wb_dat_o;
    logic        tmo;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int stall_hits = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ivl_timer u_ivl_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_dat_i(wb_dat_i),
        .wb_ack(wb_ack), .wb_stall(wb_stall), .wb_dat_o(wb_dat_o), .tmo(tmo)
    );

    // Tally tmo pulses and any stall seen on the bus.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (tmo) pulses <= pulses + 1;
        if (wb_stall) stall_hits <= stall_hits + 1;
    end

    // Vector table: write word, enabled edges, expected read-back, expected pulses.
    localparam int NV = 10;
    localparam logic [31:0] V_WR [NV] = '{32'h0000_000A, 32'h0000_0005, 32'h0000_0005,
        32'h8000_0004, 32'h8000_0004, 32'h0000_0000, 32'h8000_0000, 32'h0000_0001,
        32'h8000_0001, 32'h7FFF_FFFF};
    localparam int V_RUN [NV] = '{3, 5, 9, 4, 10, 6, 6, 1, 3, 2};
    localparam logic [31:0] V_RD [NV] = '{32'h0000_0007, 32'h0000_0000, 32'h0000_0000,
        32'h8000_0004, 32'h8000_0002, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000,
        32'h8000_0001, 32'h7FFF_FFFD};
    localparam int V_IRQ [NV] = '{0, 1, 1, 1, 2, 0, 0, 1, 3, 0};
    localparam string V_REQ [NV] = '{"R4", "R6", "R6", "R7", "R7", "R8", "R8", "R6", "R7", "R2"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_dat_i = d;
        @(negedge clk);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    endtask

    // Read with R3 timing checks: ack high one clock after the strobe, then low.
    task automatic bus_read(output logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0;
        @(negedge clk);
        wb_cyc = 1'b0; wb_stb = 1'b0;
        check("R3 ack", {31'b0, wb_ack}, 32'h1);
        d = wb_dat_o;
        @(negedge clk);
        check("R3 ack drop", {31'b0, wb_ack}, 32'h0);
    endtask

    task automatic run_for(input int n);
        @(negedge clk);
        run_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        int p0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 tmo", {31'b0, tmo}, 32'h0);
        check("R1 ack", {31'b0, wb_ack}, 32'h0);
        rst_n = 1'b1;
        bus_read(rd);
        check("R1 count", rd, 32'h0);

        for (int v = 0; v < NV; v++) begin
            bus_write(V_WR[v]);
            p0 = pulses;
            run_for(V_RUN[v]);
            bus_read(rd);
            check(V_REQ[v], rd, V_RD[v]);
            check({V_REQ[v], " pulses"}, 32'(pulses - p0), 32'(V_IRQ[v]));
        end

        // R5: hold while run_en low
        bus_write(32'h0000_0010);
        repeat (5) @(negedge clk);
        bus_read(rd);
        check("R5 hold", rd, 32'h0000_0010);

        // R9: write on the same edge as an enabled decrement
        @(negedge clk);
        run_en = 1'b1;
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_dat_i = 32'h0000_0008;
        @(negedge clk);
        run_en = 1'b0;
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        bus_read(rd);
        check("R9 write wins", rd, 32'h0000_0008);

        // R10: strobe without cyc is ignored
        @(negedge clk);
        wb_stb = 1'b1; wb_we = 1'b1; wb_dat_i = 32'h0000_0003;
        @(negedge clk);
        wb_stb = 1'b0; wb_we = 1'b0;
        check("R10 no ack", {31'b0, wb_ack}, 32'h0);
        bus_read(rd);
        check("R10 unchanged", rd, 32'h0000_0008);

        // R1: reset in the middle of an auto-reload run
        bus_write(32'h8000_0020);
        @(negedge clk);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        run_en = 1'b0;
        rst_n = 1'b1;
        bus_read(rd);
        check("R1 mid-run reset", rd, 32'h0);

        // R3: stall never seen
        check("R3 stall", 32'(stall_hits), 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles > 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule